// File: doc/BRIEF.md
# Frame-Swapped Double-Bank Receive Store

This block buffers the payload of a periodic, unacknowledged OUT endpoint. It holds two equal banks of `MAX_PKT` bytes each. At any time one bank is the background bank and the other is the foreground bank. The bus-side receiver fills the background bank one byte at a time. The processor drains the foreground bank through a byte stream port and can look at its remaining byte count and its status flags. A start-of-frame pulse exchanges the two roles. After the exchange, the bank that just became background starts from zero bytes and clear flags, so data from two frames is never merged.

The receive side has no flow control. The bus cannot be stalled, so it never sees back-pressure. Bytes beyond the bank size are dropped and recorded in a flag. A packet error marks the whole frame as bad. If a start-of-frame pulse arrives while a packet is still being written, the exchange waits until that packet ends. The block raises no handshake and no completion interrupt.

The processor-side read port is a valid/ready stream, gated by an endpoint-select input. While `rd_valid` is high and `rd_ready` is low, the byte on offer and the remaining count hold still. A byte is consumed only in a cycle where both are high. Dropping `ep_sel` withdraws `rd_valid`, and in that state `rd_ready` has no effect.

Top module: `iso_rx_pingpong`

## Requirements
- R1: After reset, `fg_count` is 0, `fg_empty` is 1, `fg_ovf` and `fg_err` are 0, and `rd_valid` is 0.
- R2: Bytes written to the background bank do not change `fg_count`. On the clock edge where an exchange happens, `fg_count` takes the number of bytes the background bank held, and `fg_empty` is 1 exactly when `fg_count` is 0.
- R3: `rd_valid` is 1 exactly when `ep_sel` is 1 and `fg_count` is non-zero. Bytes leave in the order they arrived. Each cycle with `rd_valid` and `rd_ready` both high lowers `fg_count` by one.
- R4: While `rd_valid` is 1, `rd_ready` is 0 and no exchange happens, `rd_data` and `fg_count` stay unchanged.
- R5: An exchange discards any unread foreground bytes. The new background bank starts empty, so two exchanges with no bytes between them leave `fg_count` at 0.
- R6: A byte that arrives while the background bank already holds `MAX_PKT` bytes is dropped. When that bank becomes foreground, `fg_ovf` reads 1 and `fg_count` never exceeds `MAX_PKT`.
- R7: `pkt_err` empties the background bank, and every further byte of that frame is dropped. After the exchange, `fg_count` is 0 and `fg_err` is 1.
- R8: An exchange happens on an edge where `sof` is high, or a deferred exchange is pending, and no packet is in progress past that edge. A packet is in progress from its first `in_valid` byte until the edge that carries `pkt_end` or `pkt_err`. A byte that arrives together with `pkt_end` belongs to the packet. A deferred exchange takes effect on that closing edge.
- R9: While `ep_sel` is 0, `rd_ready` has no effect and `fg_count` does not change, unless an exchange happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte strobe (no back-pressure) |
| in_data | input | 8 | Received byte |
| pkt_end | input | 1 | Packet ended without error |
| pkt_err | input | 1 | Packet ended with an error |
| sof | input | 1 | Start-of-frame pulse |
| ep_sel | input | 1 | Processor has the endpoint selected |
| rd_ready | input | 1 | Processor accepts the offered byte |
| rd_valid | output | 1 | A foreground byte is on offer |
| rd_data | output | 8 | Offered foreground byte |
| fg_count | output | $clog2(MAX_PKT+1) | Bytes left in the foreground bank |
| fg_empty | output | 1 | Foreground bank has no bytes left |
| fg_ovf | output | 1 | Foreground frame lost bytes to a full bank |
| fg_err | output | 1 | Foreground frame was hit by a packet error |

## Verification
The assertions assume that `pkt_end` and `pkt_err` are never high in the same cycle. They also assume that an exchange is caused only by `sof`, `pkt_end` or `pkt_err`, so the hold checks exclude cycles where any of these is high. The random stimulus draws the packet-close strobe as a single choice between end, error or neither, so the two can never coincide. `sof`, the byte strobe, selection and ready are each drawn independently, which makes deferred exchanges, overflows and back-pressure all appear with a bank size of 8.

// File: rtl/irp_pkg.sv
package irp_pkg;
  typedef logic [7:0] byte_t;

  typedef struct packed {
    logic ovf;
    logic err;
  } bank_flags_t;
endpackage

// File: rtl/irp_swap_ctrl.sv
module irp_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic pkt_end,
  input  logic pkt_err,
  input  logic sof,
  output logic swap,
  output logic fg_idx
);
  logic in_pkt;
  logic pend;
  logic busy;
  logic want;

  // A packet stays open past this edge unless it is being closed now.
  assign busy = (in_pkt | in_valid) & ~(pkt_end | pkt_err);
  assign want = sof | pend;
  assign swap = want & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      pend   <= 1'b0;
      fg_idx <= 1'b0;
    end else begin
      in_pkt <= busy;
      pend   <= want & busy;
      fg_idx <= fg_idx ^ swap;
    end
  end
endmodule

// File: rtl/irp_wr_ctrl.sv
module irp_wr_ctrl
  import irp_pkg::*;
#(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        pkt_err,
  input  logic        swap,
  input  logic        fg_idx,
  output logic        wr_en,
  output logic        wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] cnt [2],
  output bank_flags_t flags [2]
);
  localparam logic [CW-1:0] FULL = CW'(MAX_PKT);

  logic bg;
  assign bg      = ~fg_idx;
  assign wr_bank = bg;
  assign wr_addr = cnt[bg][AW-1:0];
  assign wr_en   = in_valid & ~pkt_err & ~flags[bg].err & (cnt[bg] != FULL);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic is_bg;
    assign is_bg = (b[0] != fg_idx);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[b]   <= '0;
        flags[b] <= '0;
      end else if (swap && !is_bg) begin
        // The old foreground becomes the new background: start it clean.
        cnt[b]   <= '0;
        flags[b] <= '0;
      end else if (is_bg) begin
        if (pkt_err) begin
          cnt[b]       <= '0;
          flags[b].err <= 1'b1;
        end else if (in_valid && !flags[b].err) begin
          if (cnt[b] == FULL) flags[b].ovf <= 1'b1;
          else                cnt[b]       <= cnt[b] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irp_bank_mem.sv
module irp_bank_mem
  import irp_pkg::*;
#(
  parameter int MAX_PKT = 64,
  localparam int AW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  byte_t         wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output byte_t         rd_data
);
  byte_t bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_store
    byte_t mem [MAX_PKT];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == b[0])) mem[wr_addr] <= wr_data;
    end

    assign bank_q[b] = mem[rd_addr];
  end

  assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/irp_rd_port.sv
module irp_rd_port #(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap,
  input  logic          ep_sel,
  input  logic          rd_ready,
  input  logic [CW-1:0] fg_fill,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] remaining
);
  logic [CW-1:0] rptr;

  assign remaining = fg_fill - rptr;
  assign rd_valid  = ep_sel & (remaining != '0);
  assign rd_addr   = rptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                 rptr <= '0;
    else if (swap)              rptr <= '0;
    else if (rd_valid && rd_ready) rptr <= rptr + 1'b1;
  end
endmodule

// File: rtl/iso_rx_pingpong.sv
module iso_rx_pingpong
  import irp_pkg::*;
#(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          pkt_end,
  input  logic          pkt_err,
  input  logic          sof,
  input  logic          ep_sel,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] fg_count,
  output logic          fg_empty,
  output logic          fg_ovf,
  output logic          fg_err
);
  logic          swap;
  logic          fg_idx;
  logic          wr_en;
  logic          wr_bank;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] cnt [2];
  bank_flags_t   flags [2];

  irp_swap_ctrl u_swap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pkt_end(pkt_end),
    .pkt_err(pkt_err), .sof(sof), .swap(swap), .fg_idx(fg_idx)
  );

  irp_wr_ctrl #(.MAX_PKT(MAX_PKT)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pkt_err(pkt_err),
    .swap(swap), .fg_idx(fg_idx), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .cnt(cnt), .flags(flags)
  );

  irp_bank_mem #(.MAX_PKT(MAX_PKT)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(in_data), .rd_bank(fg_idx), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  irp_rd_port #(.MAX_PKT(MAX_PKT)) u_rd (
    .clk(clk), .rst_n(rst_n), .swap(swap), .ep_sel(ep_sel),
    .rd_ready(rd_ready), .fg_fill(cnt[fg_idx]), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .remaining(fg_count)
  );

  assign fg_empty = (fg_count == '0);
  assign fg_ovf   = flags[fg_idx].ovf;
  assign fg_err   = flags[fg_idx].err;
endmodule

// File: rtl/irp_checker.sv
module irp_checker #(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          pkt_end,
  input logic          pkt_err,
  input logic          sof,
  input logic          ep_sel,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic [7:0]    rd_data,
  input logic [CW-1:0] fg_count,
  input logic          fg_empty
);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fg_count <= CW'(MAX_PKT));

  assert_valid_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ep_sel && !fg_empty));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !sof && !pkt_end && !pkt_err)
      |=> ($stable(rd_data) && $stable(fg_count)));

  assert_desel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_sel && !sof && !pkt_end && !pkt_err) |=> $stable(fg_count));

  assert_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && in_valid && !pkt_end && !pkt_err && !(rd_valid && rd_ready))
      |=> $stable(fg_count));

  assert_close_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_end && pkt_err));
endmodule

bind iso_rx_pingpong irp_checker #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pkt_end(pkt_end),
  .pkt_err(pkt_err), .sof(sof), .ep_sel(ep_sel), .rd_ready(rd_ready),
  .rd_valid(rd_valid), .rd_data(rd_data), .fg_count(fg_count),
  .fg_empty(fg_empty)
);

// File: tb/sim_iso_rx_pingpong.sv
`timescale 1ns/1ps
module sim_iso_rx_pingpong;
  localparam int MAXP = 8;
  localparam int CW = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, pkt_end = 0, pkt_err = 0, sof = 0, ep_sel = 0, rd_ready = 0;
  logic [7:0] in_data = '0;
  logic rd_valid, fg_empty, fg_ovf, fg_err;
  logic [7:0] rd_data;
  logic [CW-1:0] fg_count;

  always #5 clk = ~clk;

  iso_rx_pingpong #(.MAX_PKT(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .pkt_end(pkt_end), .pkt_err(pkt_err), .sof(sof), .ep_sel(ep_sel),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .fg_count(fg_count), .fg_empty(fg_empty), .fg_ovf(fg_ovf), .fg_err(fg_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model of the requirements
  byte unsigned q_fg[$];
  byte unsigned q_bg[$];
  bit m_fovf, m_ferr, m_bovf, m_berr, m_inpkt, m_pend;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_valid();
    return (ep_sel && q_fg.size() != 0) ? 1 : 0;
  endfunction

  task automatic compare_all();
    chk("R2 count", int'(fg_count), q_fg.size());
    chk("R2 empty", int'(fg_empty), (q_fg.size() == 0) ? 1 : 0);
    chk("R6 ovf", int'(fg_ovf), int'(m_fovf));
    chk("R7 err", int'(fg_err), int'(m_ferr));
    chk(ep_sel ? "R3 valid" : "R9 valid", int'(rd_valid), exp_valid());
    if (exp_valid() != 0) chk("R4 data", int'(rd_data), int'(q_fg[0]));
  endtask

  // Model update at one clock edge, from the inputs applied this cycle.
  task automatic model_edge(bit v, byte unsigned d, bit e, bit er, bit s, bit pop);
    bit busy, swp;
    if (pop) void'(q_fg.pop_front());
    if (v && !er && !m_berr) begin
      if (q_bg.size() == MAXP) m_bovf = 1;
      else q_bg.push_back(d);
    end
    if (er) begin q_bg.delete(); m_berr = 1; end
    busy = (m_inpkt || v) && !(e || er);
    swp  = (s || m_pend) && !busy;
    m_pend  = (s || m_pend) && busy;
    m_inpkt = busy;
    if (swp) begin
      q_fg = q_bg; m_fovf = m_bovf; m_ferr = m_berr;
      q_bg.delete(); m_bovf = 0; m_berr = 0;
    end
  endtask

  // Called just after a falling edge; ends just after the next falling edge.
  task automatic step(bit v, byte unsigned d, bit e, bit er, bit s, bit sl, bit rd);
    bit pop;
    in_valid = v; in_data = d; pkt_end = e; pkt_err = er; sof = s;
    ep_sel = sl; rd_ready = rd;
    #1;
    compare_all();
    pop = (exp_valid() != 0) && rd;
    @(posedge clk);
    model_edge(v, d, e, er, s, pop);
    @(negedge clk);
  endtask

  task automatic idle(int n, bit sl);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, sl, 0);
  endtask

  task automatic send(int n, int base);
    for (int i = 0; i < n; i++) step(1, 8'(base + i), 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ep_sel = 1'b1;
    #1;
    // R1 reset state
    chk("R1 count", int'(fg_count), 0);
    chk("R1 empty", int'(fg_empty), 1);
    chk("R1 flags", int'({fg_ovf, fg_err}), 0);
    chk("R1 valid", int'(rd_valid), 0);
    @(negedge clk);

    // R2: a packet stays hidden until the exchange
    send(5, 8'h10);
    step(0, 0, 1, 0, 0, 1, 0);
    chk("R2 hidden", int'(fg_count), 0);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R2 swapped", int'(fg_count), 5);
    // R3: drain two bytes in order
    step(0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R3 popped", int'(fg_count), 3);
    // R9: ready without select does nothing
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R9 desel", int'(fg_count), 3);
    // R5: unread bytes discarded, new background empty
    step(0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R5 discard", int'(fg_count), 0);

    // R6: overflow
    send(MAXP + 2, 8'h40);
    step(0, 0, 1, 0, 1, 1, 0);
    chk("R6 full count", int'(fg_count), MAXP);
    chk("R6 ovf flag", int'(fg_ovf), 1);

    // R7: packet error invalidates the frame
    send(3, 8'h60);
    step(0, 0, 0, 1, 0, 1, 0);
    send(2, 8'h70);
    step(0, 0, 1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R7 count", int'(fg_count), 0);
    chk("R7 err flag", int'(fg_err), 1);

    // R8: deferred exchange
    idle(1, 1);
    step(0, 0, 0, 0, 1, 1, 0);
    send(2, 8'h80);
    step(1, 8'h82, 0, 0, 1, 1, 0);
    chk("R8 deferred", int'(fg_count), 0);
    step(1, 8'h83, 0, 0, 0, 1, 0);
    chk("R8 still", int'(fg_count), 0);
    step(1, 8'h84, 1, 0, 0, 1, 0);
    chk("R8 closed", int'(fg_count), 5);
    chk("R8 first", int'(rd_data), 8'h80);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      int c;
      bit e, er;
      c  = $urandom_range(99);
      e  = (c < 6);
      er = (c >= 6 && c < 8);
      step($urandom_range(99) < 45, 8'($urandom), e, er,
           $urandom_range(99) < 4, $urandom_range(99) < 70,
           $urandom_range(99) < 55);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule